// File: doc/BRIEF.md
# Byte-Lane Static Memory Core

This block is a word-organised static memory with an active-low control interface of the kind used by asynchronous SRAM parts. It is modelled for a clocked simulation environment. Each word is split into 8-bit byte lanes, and every lane has its own active-low enable. A write stores only the lanes whose enables are low. A read drives only those lanes and reports, one bit per lane, which lanes are driven. That flag vector stands in for the tri-state pad control that a real device would use.

The data-in and data-out buses are separate. A write commits on the rising clock edge while the write condition holds. Read data is combinational from the current address and the current contents. A deselected core raises a power-down flag, and its contents are held through any deselected period. The full-size configuration is `ADDR_W = 16` and `DATA_W = 16`, which gives 65,536 words of 16 bits. The default parameters give a 1,024-word array so that elaboration stays light.

Top module: `bytelane_sram`

## Requirements
- R1: On a rising clock edge with cs_n=0 and wr_n=0, the low lane (bits 7:0) of the addressed word takes wdata[7:0] only if lane_n[0]=0; otherwise that lane keeps its old value.
- R2: On the same write condition, the high lane (bits 15:8) takes wdata[15:8] only if lane_n[1]=0; otherwise that lane keeps its old value. With both lane enables high, a write changes nothing.
- R3: A read happens when cs_n=0, rd_n=0 and wr_n=1. During a read, rdata_en[0] is 1 exactly when lane_n[0]=0, and rdata_en[1] is 1 exactly when lane_n[1]=0. Each driven lane shows that lane of the stored word at the current address, with no clock delay.
- R4: A lane whose rdata_en bit is 0 reads as 0x00 on rdata.
- R5: rdata_en is 0 whenever cs_n=1, whenever rd_n=1, or whenever both lane_n bits are 1.
- R6: During a write (cs_n=0 and wr_n=0), rdata_en is 0 even when rd_n=0.
- R7: pwr_down is 1 exactly when cs_n=1. While pwr_down is 1, a low wr_n does not alter the memory.
- R8: Stored contents survive deselected periods and intervening accesses to other addresses. Every address holds its own word independently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes commit on its rising edge |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write enable |
| rd_n | input | 1 | Active-low output enable |
| lane_n | input | DATA_W/8 | Active-low byte-lane enables, bit 0 = bits 7:0 |
| rdata | output | DATA_W | Read data, undriven lanes forced to zero |
| rdata_en | output | DATA_W/8 | Per-lane output-drive flag |
| pwr_down | output | 1 | High while the core is deselected |

## Verification
Some rules are checked by the assertions on every cycle. Those rules are: the drive flags stay low during writes, during deselect, with output disabled and with both lanes disabled; a flag never rises for a lane whose enable is high; an undriven lane reads zero; and the lanes written at the latest write edge hold exactly the data presented. Other rules need scenarios from the bench. Those are: lanes left out of a write keep their earlier values, writes attempted while deselected leave contents untouched, and each of the 1,024 addresses holds its word against a reference array. The bench sweeps every address with full-word, low-only and high-only writes, and reads back under each lane-enable combination.

// File: rtl/bytelane_sram.sv
module bytelane_sram #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic                  clk,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wdata,
  input  logic                  cs_n,
  input  logic                  wr_n,
  input  logic                  rd_n,
  input  logic [DATA_W/8-1:0]   lane_n,
  output logic [DATA_W-1:0]     rdata,
  output logic [DATA_W/8-1:0]   rdata_en,
  output logic                  pwr_down
);
  localparam int LANES = DATA_W / 8;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] word;
  logic              wr_cyc, rd_cyc;
  logic [LANES-1:0]  lane_we;

  assign wr_cyc   = !cs_n && !wr_n;
  assign rd_cyc   = !cs_n && !rd_n && wr_n;
  assign lane_we  = {LANES{wr_cyc}} & ~lane_n;
  assign rdata_en = {LANES{rd_cyc}} & ~lane_n;
  assign pwr_down = cs_n;
  assign word     = mem[addr];

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++)
      if (lane_we[l]) mem[addr][l*8 +: 8] <= wdata[l*8 +: 8];
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rdata[g*8 +: 8] = rdata_en[g] ? word[g*8 +: 8] : 8'h00;
  end

  logic              chk_v = 1'b0;
  logic [ADDR_W-1:0] chk_a;
  logic [DATA_W-1:0] chk_d, chk_word;
  logic [DATA_W-1:0] chk_m;

  always_ff @(posedge clk) begin
    if (wr_cyc && lane_we != '0) begin
      chk_v <= 1'b1;
      chk_a <= addr;
      chk_d <= wdata;
      for (int l = 0; l < LANES; l++) chk_m[l*8 +: 8] <= {8{lane_we[l]}};
    end
  end

  assign chk_word = mem[chk_a];

  always_comb begin
    if (wr_cyc) AST_WRITE_SILENT: assert (rdata_en == '0) else $error("drive during write"); // R6
    if (cs_n || rd_n || (&lane_n)) AST_QUIET_OUT: assert (rdata_en == '0) else $error("drive while disabled"); // R5
    AST_LANE_GATE: assert ((rdata_en & lane_n) == '0) else $error("lane driven without enable"); // R3
    if (pwr_down) AST_PWRDN_SILENT: assert (rdata_en == '0) else $error("drive in power-down"); // R7
    for (int l = 0; l < LANES; l++)
      if (!rdata_en[l]) AST_UNDRIVEN_ZERO: assert (rdata[l*8 +: 8] == 8'h00) else $error("undriven lane nonzero"); // R4
    if (chk_v) AST_WRITE_COMMIT: assert (((chk_word ^ chk_d) & chk_m) == '0) else $error("written lanes lost"); // R1
  end
endmodule

// File: tb/tb_bytelane_sram.sv
module tb_bytelane_sram;
  localparam int AW = 10;
  localparam int DW = 16;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
  logic [1:0]    lane_n = 2'b11;
  logic [DW-1:0] rdata;
  logic [1:0]    rdata_en;
  logic          pwr_down;

  logic [DW-1:0] ref_mem [N];
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  bytelane_sram #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .addr(addr), .wdata(wdata), .cs_n(cs_n), .wr_n(wr_n),
    .rd_n(rd_n), .lane_n(lane_n), .rdata(rdata), .rdata_en(rdata_en),
    .pwr_down(pwr_down));

  function automatic logic [DW-1:0] pat(int a, int s);
    return DW'((a * 40503 + s * 7919) ^ (s << 5));
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [DW-1:0] d, logic [1:0] ln, logic cs);
    @(negedge clk);
    addr = AW'(a); wdata = d; lane_n = ln; cs_n = cs; wr_n = 1'b0; rd_n = 1'b0;
    #1;
    check("R6", {30'd0, rdata_en}, 32'd0);
    @(posedge clk);
    if (!cs) begin
      if (!ln[0]) ref_mem[a][7:0]  = d[7:0];
      if (!ln[1]) ref_mem[a][15:8] = d[15:8];
    end
    @(negedge clk);
    wr_n = 1'b1; rd_n = 1'b1; cs_n = 1'b1; lane_n = 2'b11;
  endtask

  task automatic rd(string req, int a, logic [1:0] ln);
    logic [DW-1:0] m;
    @(negedge clk);
    addr = AW'(a); lane_n = ln; cs_n = 1'b0; wr_n = 1'b1; rd_n = 1'b0;
    #1;
    m = {{8{~ln[1]}}, {8{~ln[0]}}};
    check(req, {30'd0, rdata_en}, {30'd0, ~ln});
    check(req, {16'd0, rdata}, {16'd0, ref_mem[a] & m});
    cs_n = 1'b1; rd_n = 1'b1; lane_n = 2'b11;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1;
    check("R7 reset pwr_down", {31'd0, pwr_down}, 32'd1);
    check("R5 reset rdata_en", {30'd0, rdata_en}, 32'd0);
    check("R4 reset rdata", {16'd0, rdata}, 32'd0);

    for (int a = 0; a < N; a++) wr(a, pat(a, 1), 2'b00, 1'b0);
    for (int a = 0; a < N; a++) rd("R8 full sweep", a, 2'b00);

    for (int a = 0; a < N; a += 3) wr(a, pat(a, 2), 2'b10, 1'b0);
    for (int a = 0; a < N; a += 3) rd("R1 low-only write", a, 2'b00);
    for (int a = 1; a < N; a += 3) wr(a, pat(a, 3), 2'b01, 1'b0);
    for (int a = 1; a < N; a += 3) rd("R2 high-only write", a, 2'b00);
    for (int a = 2; a < N; a += 7) wr(a, pat(a, 4), 2'b11, 1'b0);
    for (int a = 2; a < N; a += 7) rd("R2 no-lane write", a, 2'b00);

    for (int a = 0; a < N; a += 5) begin
      rd("R3 low lane read", a, 2'b10);
      rd("R3 high lane read", a, 2'b01);
      rd("R5 no lane read", a, 2'b11);
    end

    for (int a = 0; a < N; a += 11) wr(a, pat(a, 5), 2'b00, 1'b1);
    for (int a = 0; a < N; a += 11) rd("R7 deselected write ignored", a, 2'b00);

    @(negedge clk);
    addr = AW'(17); lane_n = 2'b00; cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b0; #1;
    check("R5 cs_n high", {30'd0, rdata_en}, 32'd0);
    check("R7 pwr_down high", {31'd0, pwr_down}, 32'd1);
    cs_n = 1'b0; rd_n = 1'b1; #1;
    check("R5 rd_n high", {30'd0, rdata_en}, 32'd0);
    check("R4 rd_n high data", {16'd0, rdata}, 32'd0);
    check("R7 pwr_down low", {31'd0, pwr_down}, 32'd0);
    rd_n = 1'b0; lane_n = 2'b11; #1;
    check("R5 both lanes off", {30'd0, rdata_en}, 32'd0);
    cs_n = 1'b1; rd_n = 1'b1;

    repeat (20) @(negedge clk);
    for (int a = 0; a < N; a++) rd("R8 retention", a, 2'b00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule